// File: doc/BRIEF.md
# Interrupt Priority Mask and Acknowledge Controller

This block watches a three-bit interrupt level driven by peripherals. Level 0 means that nothing is requested. The block compares the level with a mask that it holds in its own register. The mask names the highest level that is still ignored, so a request is taken only when its level is strictly above the mask. The raw level is sampled on successive rising clock edges. A value counts as stable only when every sample in the sampling window agrees. This keeps a glitch or a level in transition from ever being compared.

When a stable level beats the mask, the block raises `pending` and latches the level onto `pend_level`. It drives the transfer-type pins to the acknowledge encoding and pulses `ack_strobe` for one cycle to start the acknowledge bus cycle. The bus logic signals the end of that cycle on `ack_done`. The block then drops `pending` and spends a short recovery window in which it takes no new request. During that window the requester removes its level and the sampling chain flushes.

The controller is a four-state machine. IDLE compares the stable level with the mask. START is a one-cycle state that carries the strobe. HOLD keeps the request presented until the cycle completes. RECOVER is the post-acknowledge guard. The transitions are:
- IDLE→START when the stable level exceeds the mask.
- START→HOLD when `ack_done` is low.
- START→RECOVER or HOLD→RECOVER when `ack_done` is high.
- RECOVER→IDLE when the guard counter reaches zero.

Top module: `irq_prio_ack`

## Requirements
- R1: After reset, `pending` and `ack_strobe` are 0, `tt` is 2'b00 and the mask holds 7. With that mask, a level of 7 is never accepted.
- R2: A level is used only after two consecutive clock samples of it agree. A level that is present for a single cycle, or that alternates every cycle, never causes `pending`.
- R3: With the FSM in IDLE, a stable level L causes `pending` only when L > mask. Level 0 never causes `pending`.
- R4: If a qualifying level is applied before rising edge 0 and held, `pending` is first seen high after rising edge 3.
- R5: `ack_strobe` is high for exactly one cycle, the first cycle in which `pending` is high (START).
- R6: `tt` is 2'b11 (acknowledge type) whenever `pending` is high and 2'b00 otherwise.
- R7: While `pending` is high, `pend_level` holds the level that was accepted. Later changes of `irq_level` do not alter it.
- R8: `ack_done` high on an edge where `pending` is high clears `pending` at that edge. No new request is accepted for the next 3 cycles. A level still held after that is accepted again one cycle later, so `pending` reappears after the 5th edge from the one that cleared it (that edge counted as the 1st).
- R9: A write through `mask_wr`/`mask_in` updates the mask at that edge, and the comparison at the next edge uses the new value. A mask write while `pending` is high does not clear `pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_level | input | 3 | Requested priority level, 0 = none |
| mask_in | input | 3 | New mask value |
| mask_wr | input | 1 | Mask write strobe |
| ack_done | input | 1 | Acknowledge bus cycle has completed |
| pending | output | 1 | An interrupt is pending acknowledge |
| pend_level | output | 3 | Level of the pending interrupt |
| tt | output | 2 | Transfer type, 2'b11 during acknowledge |
| ack_strobe | output | 1 | One-cycle start of acknowledge cycle |

## Verification
The assertions check, on every cycle:
- that the transfer type follows `pending` and that the strobe only accompanies the first cycle of `pending`;
- that `pend_level` stays frozen until `ack_done`, and that `ack_done` clears `pending` at once;
- that every accepted level is nonzero and lies strictly above the mask in force at the comparison.

Only the bench scenarios can show the rest:
- the exact latency from a level change to `pending`;
- that glitching or alternating levels are rejected;
- the full sweep of every level against every mask;
- the length of the recovery window;
- that a new mask governs the very next comparison.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_START   = 2'd1,
        ST_HOLD    = 2'd2,
        ST_RECOVER = 2'd3
    } ack_state_e;

    localparam logic [1:0] TT_NORMAL = 2'b00;
    localparam logic [1:0] TT_ACK    = 2'b11;

endpackage

// File: rtl/irq_level_filter.sv
module irq_level_filter #(
    parameter int W     = 3,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_raw,
    output logic [W-1:0] lvl_stable
);

    logic [DEPTH-1:0][W-1:0] smp_q;
    logic                    agree;
    logic [W-1:0]            stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q[0] <= lvl_raw;
            for (int i = 1; i < DEPTH; i++) begin
                smp_q[i] <= smp_q[i-1];
            end
        end
    end

    generate
        if (DEPTH > 1) begin : g_vote
            always_comb begin
                agree = 1'b1;
                for (int j = 1; j < DEPTH; j++) begin
                    if (smp_q[j] != smp_q[0]) begin
                        agree = 1'b0;
                    end
                end
            end
        end else begin : g_single
            assign agree = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable_q <= '0;
        end else if (agree) begin
            stable_q <= smp_q[0];
        end
    end

    assign lvl_stable = stable_q;

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en) begin
            mask_q <= wr_data;
        end
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_ack_pkg::*;
#(
    parameter int W         = 3,
    parameter int RECOV_CYC = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_stable,
    input  logic [W-1:0] mask_q,
    input  logic         ack_done,
    output logic         pending,
    output logic [W-1:0] pend_level,
    output logic [1:0]   tt,
    output logic         ack_strobe
);

    localparam int CNT_W = (RECOV_CYC > 1) ? $clog2(RECOV_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOV_CYC - 1);

    ack_state_e       state_q, state_d;
    logic [CNT_W-1:0] guard_q;
    logic [W-1:0]     level_q;
    logic             take_req;

    assign take_req = (lvl_stable > mask_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take_req) state_d = ST_START;
            ST_START:   state_d = ack_done ? ST_RECOVER : ST_HOLD;
            ST_HOLD:    if (ack_done) state_d = ST_RECOVER;
            ST_RECOVER: if (guard_q == '0) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // guard counter and captured level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guard_q <= '0;
            level_q <= '0;
        end else begin
            if (state_q == ST_IDLE && take_req) begin
                level_q <= lvl_stable;
            end
            if (state_q != ST_RECOVER && state_d == ST_RECOVER) begin
                guard_q <= CNT_LOAD;
            end else if (state_q == ST_RECOVER && guard_q != '0) begin
                guard_q <= guard_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pending    = 1'b0;
        ack_strobe = 1'b0;
        tt         = TT_NORMAL;
        pend_level = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_START: begin
                pending    = 1'b1;
                ack_strobe = 1'b1;
                tt         = TT_ACK;
                pend_level = level_q;
            end
            ST_HOLD: begin
                pending    = 1'b1;
                tt         = TT_ACK;
                pend_level = level_q;
            end
            ST_RECOVER: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/irq_prio_ack.sv
module irq_prio_ack #(
    parameter int LVL_W       = 3,
    parameter int MATCH_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] mask_in,
    input  logic             mask_wr,
    input  logic             ack_done,
    output logic             pending,
    output logic [LVL_W-1:0] pend_level,
    output logic [1:0]       tt,
    output logic             ack_strobe
);

    localparam int RECOV_CYC = MATCH_DEPTH + 1;

    logic [LVL_W-1:0] lvl_stable;
    logic [LVL_W-1:0] mask_q;

    irq_level_filter #(.W(LVL_W), .DEPTH(MATCH_DEPTH)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_raw    (irq_level),
        .lvl_stable (lvl_stable)
    );

    irq_mask_reg #(.W(LVL_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr),
        .wr_data (mask_in),
        .mask_q  (mask_q)
    );

    irq_ack_fsm #(.W(LVL_W), .RECOV_CYC(RECOV_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_stable (lvl_stable),
        .mask_q     (mask_q),
        .ack_done   (ack_done),
        .pending    (pending),
        .pend_level (pend_level),
        .tt         (tt),
        .ack_strobe (ack_strobe)
    );

endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk #(
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pending,
    input logic         ack_strobe,
    input logic [1:0]   tt,
    input logic [W-1:0] pend_level,
    input logic         ack_done,
    input logic [W-1:0] mask_q
);

    // R6
    tt_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> tt == 2'b11);
    // R6
    tt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> tt == 2'b00);
    // R5
    strobe_in_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_strobe |-> pending);
    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_strobe |=> !ack_strobe);
    // R5
    strobe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> ack_strobe);
    // R7
    level_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack_done) |=> (pending && $stable(pend_level)));
    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && ack_done) |=> !pending);
    // R3
    above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> (pend_level > $past(mask_q) && pend_level != '0));

endmodule

bind irq_prio_ack irq_ack_chk #(.W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pending    (pending),
    .ack_strobe (ack_strobe),
    .tt         (tt),
    .pend_level (pend_level),
    .ack_done   (ack_done),
    .mask_q     (mask_q)
);

// File: tb/irq_prio_ack_tb.sv
module irq_prio_ack_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] irq_level = '0;
    logic [2:0] mask_in = '0;
    logic       mask_wr = 1'b0;
    logic       ack_done = 1'b0;
    logic       pending;
    logic [2:0] pend_level;
    logic [1:0] tt;
    logic       ack_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ack u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_level  (irq_level),
        .mask_in    (mask_in),
        .mask_wr    (mask_wr),
        .ack_done   (ack_done),
        .pending    (pending),
        .pend_level (pend_level),
        .tt         (tt),
        .ack_strobe (ack_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_mask(input logic [2:0] m);
        mask_in = m;
        mask_wr = 1'b1;
        step(1);
        mask_wr = 1'b0;
    endtask

    task automatic ack_and_drop();
        ack_done  = 1'b1;
        irq_level = 3'd0;
        step(1);
        ack_done = 1'b0;
        chk(pending == 1'b0, "R8 ack clears", pending, 0);
        step(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int strobes;
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(pending == 1'b0, "R1 pending", pending, 0);
        chk(tt == 2'b00, "R1 tt", tt, 0);
        chk(ack_strobe == 1'b0, "R1 strobe", ack_strobe, 0);
        irq_level = 3'd7;
        step(6);
        chk(pending == 1'b0, "R1 mask=7 blocks level 7", pending, 0);
        irq_level = 3'd0;
        step(4);

        // R4 latency, R5 strobe, R6 tt
        write_mask(3'd3);
        irq_level = 3'd6;
        for (int e = 0; e < 3; e++) begin
            step(1);
            chk(pending == 1'b0, "R4 not yet pending", pending, 0);
        end
        step(1);
        chk(pending == 1'b1, "R4 pending after edge 3", pending, 1);
        chk(ack_strobe == 1'b1, "R5 strobe first cycle", ack_strobe, 1);
        chk(tt == 2'b11, "R6 tt ack", tt, 3);
        chk(pend_level == 3'd6, "R7 level", pend_level, 6);
        step(1);
        chk(ack_strobe == 1'b0, "R5 strobe one cycle", ack_strobe, 0);
        chk(pending == 1'b1, "R7 still pending", pending, 1);

        // R7 level changes ignored while pending
        irq_level = 3'd7;
        step(4);
        chk(pend_level == 3'd6, "R7 level held", pend_level, 6);

        // R9 mask write while pending keeps it
        write_mask(3'd7);
        chk(pending == 1'b1, "R9 mask write keeps pending", pending, 1);
        write_mask(3'd3);

        // R8 recovery window, held level re-accepted
        ack_done = 1'b1;
        step(1);
        ack_done = 1'b0;
        chk(pending == 1'b0, "R8 cleared", pending, 0);
        for (int k = 0; k < 3; k++) begin
            step(1);
            chk(pending == 1'b0, "R8 recovery window", pending, 0);
        end
        step(1);
        chk(pending == 1'b1, "R8 re-accepted", pending, 1);
        chk(pend_level == 3'd7, "R8 new level", pend_level, 7);
        ack_and_drop();

        // R9 mask write takes effect next comparison
        write_mask(3'd7);
        irq_level = 3'd5;
        step(5);
        chk(pending == 1'b0, "R9 masked", pending, 0);
        mask_in = 3'd4;
        mask_wr = 1'b1;
        step(1);
        mask_wr = 1'b0;
        chk(pending == 1'b0, "R9 mask edge", pending, 0);
        step(1);
        chk(pending == 1'b1, "R9 next compare", pending, 1);
        ack_and_drop();

        // R2 glitch and alternating level
        write_mask(3'd0);
        irq_level = 3'd6;
        step(1);
        irq_level = 3'd0;
        strobes = 0;
        for (int k = 0; k < 6; k++) begin
            step(1);
            if (pending) strobes++;
        end
        chk(strobes == 0, "R2 one-cycle glitch", strobes, 0);
        strobes = 0;
        for (int k = 0; k < 8; k++) begin
            irq_level = (k % 2 == 0) ? 3'd3 : 3'd5;
            step(1);
            if (pending) strobes++;
        end
        chk(strobes == 0, "R2 alternating level", strobes, 0);
        irq_level = 3'd0;
        step(4);

        // R3 sweep of every level against every mask
        for (int m = 0; m < 8; m++) begin
            for (int l = 0; l < 8; l++) begin
                bit exp;
                exp = (l > m);
                write_mask(3'(m));
                irq_level = 3'(l);
                strobes = 0;
                for (int k = 0; k < 5; k++) begin
                    step(1);
                    if (ack_strobe) strobes++;
                end
                chk(pending == exp, "R3 compare", pending, exp);
                chk(strobes == int'(exp), "R5 strobe count", strobes, exp);
                chk(tt == (exp ? 2'b11 : 2'b00), "R6 tt sweep", tt, exp ? 3 : 0);
                if (exp) begin
                    chk(pend_level == 3'(l), "R7 sweep level", pend_level, l);
                    ack_and_drop();
                end else begin
                    irq_level = 3'd0;
                    step(4);
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule